// File: doc/BRIEF.md
# Pixel Array Raster Readout Sequencer

The sequencer walks a token through the column and row shift registers of a square pixel array so that every pixel is selected in raster order. It waits a settling time for each pixel, samples the one-bit comparator and packs the results of one row into a word. That word is written to RAM once the row is complete. The first pixel of a row and the first row of the array have no flip-flop stage: the column or row data line selects them directly. A data line held high across a clock pulse therefore loads the token into the next stage. After the last column, one extra column clock empties the final column flop. One row clock then moves to the next row and reloads the column token.

A start pulse begins a frame of `SAMPLES` passes over the whole array, one sample of every pixel per pass. The row words are stored at address `pass*ROWS + row`, so with the default 32x32 array and 256 passes the addresses run from 0 up to 0x1FFF. At the end of the frame the sequencer waits idle for the next start pulse.

Top module: `pixel_raster_seq`

## Requirements
- R1: After reset and while no start pulse arrives, the column clock, row clock, both data lines, `valid_o` and `mem_we_o` are all 0.
- R2: When a row begins, its first pixel is selected with `col_d_o` high. While row 0 is being read, `row_d_o` is high. In every other row `row_d_o` is low.
- R3: The column clock pulse that follows the sample of column 0 has `col_d_o` = 1. Every later column clock pulse in the row has `col_d_o` = 0, and `col_d_o` is 0 while columns 1..COLS-1 are sampled.
- R4: Each row has exactly COLS column clock pulses. The first COLS-1 pulses each follow one sample. The last pulse is a flush after the sample of column COLS-1, and the row word is written only after this flush.
- R5: Each column or row clock pulse is high for exactly one cycle and then low for at least one cycle. Its data line has the same value in the cycle before the pulse, during the pulse and in the cycle after it.
- R6: `valid_o` is a one-cycle strobe. It rises SETTLE_CYC+1 cycles after the cycle in which a start is taken. It rises SETTLE_CYC+3 cycles after the previous strobe within a row, and SETTLE_CYC+6 cycles after it across a row boundary.
- R7: Bit c of `mem_wdata_o` equals `comp_i` in the `valid_o` cycle of column c of that row. There is exactly one write per row.
- R8: After each row write, one row clock pulse follows. It has `col_d_o` = 1 except after the last row, where the pulse flushes the row register with `col_d_o` = 0. `row_d_o` is 1 on this pulse only when it leaves row 0.
- R9: `mem_addr_o` equals pass*ROWS + row. A frame makes SAMPLES*ROWS writes, and the last address is SAMPLES*ROWS-1 (0x1FFF by default).
- R10: After the row clock of the last row of the last pass, the block returns to idle and stays there until the next start. A start pulse during a frame has no effect.
- R11: The column clock and the row clock are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame (taken only when idle) |
| comp_i | input | 1 | Comparator result of the selected pixel |
| col_d_o | output | 1 | Column token data line |
| col_clk_o | output | 1 | Column shift clock |
| row_d_o | output | 1 | Row token data line |
| row_clk_o | output | 1 | Row shift clock |
| valid_o | output | 1 | Comparator sample strobe |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM word address |
| mem_wdata_o | output | COLS | Packed row of comparator bits |

## Verification
The comparator input is driven in four patterns: random bits, constant ones, constant zeros, and random bits with extra start pulses during the frame. Random bits show whether each column lands on its own bit position in the row word. Constant words show whether any bit is stuck or never written. The frames with extra start pulses show that a start during a frame leaves the sequence and the write count unchanged. Throughout every frame the bench follows the token lines pulse by pulse. It counts the strobe spacing in cycles, so that a wrong data line level, a missing flush, a misplaced row reinjection or a wrong address is each reported against its own requirement.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_CS_HI,
    ST_CS_LO,
    ST_WRITE,
    ST_RS_HI,
    ST_RS_LO
  } rdo_state_e;
endpackage

// File: rtl/rdo_settle_timer.sv
module rdo_settle_timer #(
  parameter int unsigned LIM = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(LIM - 1));

  // R6
  settle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (32'(cnt_q) < LIM));
endmodule

// File: rtl/rdo_position.sv
module rdo_position #(
  parameter int unsigned COLS    = 32,
  parameter int unsigned ROWS    = 32,
  parameter int unsigned SAMPLES = 256,
  parameter int unsigned ADDR_W  = 13
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        col_step_i,
  input  logic                        row_step_i,
  input  logic                        wr_i,
  output logic [$clog2(COLS)-1:0]     col_o,
  output logic                        col_first_o,
  output logic                        col_last_o,
  output logic                        row_first_o,
  output logic                        row_last_o,
  output logic                        pass_last_o,
  output logic [ADDR_W-1:0]           addr_o
);
  localparam int unsigned CW    = $clog2(COLS);
  localparam int unsigned RW    = $clog2(ROWS);
  localparam int unsigned PW    = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam int unsigned TOTAL = SAMPLES * ROWS;

  logic [CW-1:0]     col_q;
  logic [RW-1:0]     row_q;
  logic [PW-1:0]     pass_q;
  logic [ADDR_W-1:0] addr_q;

  assign col_first_o = (col_q == '0);
  assign col_last_o  = (col_q == CW'(COLS - 1));
  assign row_first_o = (row_q == '0);
  assign row_last_o  = (row_q == RW'(ROWS - 1));
  assign pass_last_o = (pass_q == PW'(SAMPLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (clear_i) begin
      col_q <= '0;
    end else if (col_step_i) begin
      col_q <= col_last_o ? '0 : col_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      pass_q <= '0;
    end else if (clear_i) begin
      row_q  <= '0;
      pass_q <= '0;
    end else if (row_step_i) begin
      if (row_last_o) begin
        row_q  <= '0;
        pass_q <= pass_q + 1'b1;
      end else begin
        row_q  <= row_q + 1'b1;
      end
    end
  end

  // address walks sequentially: equals pass*ROWS + row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clear_i) addr_q <= '0;
    else if (wr_i)    addr_q <= addr_q + 1'b1;
  end

  assign col_o  = col_q;
  assign addr_o = addr_q;

  // R9
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (32'(addr_q) < TOTAL));
  // R4
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_step_i && !clear_i) |=> (col_q != $past(col_q)));
endmodule

// File: rtl/rdo_row_packer.sv
module rdo_row_packer #(
  parameter int unsigned COLS = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic [$clog2(COLS)-1:0] idx_i,
  input  logic                    bit_i,
  output logic [COLS-1:0]         word_o
);
  logic [COLS-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= '0;
    else if (cap_i) word_q[idx_i] <= bit_i;
  end

  assign word_o = word_q;

  // R7
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(word_q));
  // R7
  cap_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> (32'(idx_i) < COLS));
endmodule

// File: rtl/pixel_raster_seq.sv
module pixel_raster_seq
  import rdo_pkg::*;
#(
  parameter int unsigned COLS       = 32,
  parameter int unsigned ROWS       = 32,
  parameter int unsigned SAMPLES    = 256,
  parameter int unsigned SETTLE_CYC = 3,
  parameter int unsigned ADDR_W     = $clog2(SAMPLES * ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              comp_i,
  output logic              col_d_o,
  output logic              col_clk_o,
  output logic              row_d_o,
  output logic              row_clk_o,
  output logic              valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [COLS-1:0]   mem_wdata_o
);
  localparam int unsigned CW = $clog2(COLS);

  rdo_state_e state_q, state_d;

  logic          settle_done;
  logic          clear;
  logic [CW-1:0] col_idx;
  logic          col_first, col_last, row_first, row_last, pass_last;

  assign clear = (state_q == ST_IDLE) && start_i;

  rdo_settle_timer #(.LIM(SETTLE_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SETTLE),
    .done_o (settle_done)
  );

  rdo_position #(
    .COLS(COLS), .ROWS(ROWS), .SAMPLES(SAMPLES), .ADDR_W(ADDR_W)
  ) i_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .col_step_i  (state_q == ST_CS_LO),
    .row_step_i  (state_q == ST_RS_LO),
    .wr_i        (state_q == ST_WRITE),
    .col_o       (col_idx),
    .col_first_o (col_first),
    .col_last_o  (col_last),
    .row_first_o (row_first),
    .row_last_o  (row_last),
    .pass_last_o (pass_last),
    .addr_o      (mem_addr_o)
  );

  rdo_row_packer #(.COLS(COLS)) i_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (state_q == ST_SAMPLE),
    .idx_i  (col_idx),
    .bit_i  (comp_i),
    .word_o (mem_wdata_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = ST_CS_HI;
      ST_CS_HI:  state_d = ST_CS_LO;
      ST_CS_LO:  state_d = col_last ? ST_WRITE : ST_SETTLE;
      ST_WRITE:  state_d = ST_RS_HI;
      ST_RS_HI:  state_d = ST_RS_LO;
      ST_RS_LO:  state_d = (row_last && pass_last) ? ST_IDLE : ST_SETTLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // column token: high for column 0; around a row clock it reloads column 0,
  // except after the last row where the row register is flushed
  always_comb begin
    unique case (state_q)
      ST_SETTLE, ST_SAMPLE, ST_CS_HI, ST_CS_LO: col_d_o = col_first;
      ST_WRITE, ST_RS_HI, ST_RS_LO:             col_d_o = !row_last;
      default:                                  col_d_o = 1'b0;
    endcase
  end

  assign row_d_o   = (state_q != ST_IDLE) && row_first;
  assign col_clk_o = (state_q == ST_CS_HI);
  assign row_clk_o = (state_q == ST_RS_HI);
  assign valid_o   = (state_q == ST_SAMPLE);
  assign mem_we_o  = (state_q == ST_WRITE);

  // R11
  clk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(col_clk_o && row_clk_o));
  // R5
  col_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_clk_o |=> !col_clk_o);
  // R5
  row_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_clk_o |=> !row_clk_o);
  // R5
  col_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_clk_o |-> $stable(col_d_o));
  // R5
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_clk_o |=> $stable(col_d_o));
  // R5
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_clk_o |=> ($stable(row_d_o) && $stable(col_d_o)));
  // R6
  settle_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(state_q == ST_SETTLE));
  // R6
  valid_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !(col_d_o || row_d_o || mem_we_o || valid_o));
endmodule

// File: tb/test_pixel_raster_seq.sv
`timescale 1ns/1ps
module test_pixel_raster_seq;
  localparam int COLS = 4;
  localparam int ROWS = 3;
  localparam int SAMPLES = 3;
  localparam int SETTLE = 2;
  localparam int AW = $clog2(SAMPLES * ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic comp_i = 1'b0;
  logic col_d_o, col_clk_o, row_d_o, row_clk_o, valid_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [COLS-1:0] mem_wdata_o;

  pixel_raster_seq #(
    .COLS(COLS), .ROWS(ROWS), .SAMPLES(SAMPLES), .SETTLE_CYC(SETTLE)
  ) i_pixel_raster_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .comp_i(comp_i),
    .col_d_o(col_d_o), .col_clk_o(col_clk_o), .row_d_o(row_d_o),
    .row_clk_o(row_clk_o), .valid_o(valid_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int mode = 0;
  int frames_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // comparator stimulus changes just after each edge
  always @(posedge clk) begin
    case (mode)
      1: comp_i <= 1'b1;
      2: comp_i <= 1'b0;
      default: comp_i <= 1'($urandom);
    endcase
  end

  // reference model of the scan, driven by requirements only
  bit active = 0, first_v = 0, prev_cs = 0, prev_rs = 0, row_wr = 0;
  bit held_cd = 0, held_rd = 0;
  int start_cyc = 0, last_v = 0;
  int b_col = 0, b_cs = 0, b_row = 0, b_pass = 0, wr_cnt = 0, last_addr = -1;
  logic [COLS-1:0] row_bits;

  always @(negedge clk) if (rst_n) begin
    if (!active && (valid_o || mem_we_o || col_clk_o || row_clk_o))
      chk(0, "R10 activity while idle", 1, 0);
    if (!active && start_i) begin
      active = 1; first_v = 1; start_cyc = cyc;
      b_col = 0; b_cs = 0; b_row = 0; b_pass = 0; wr_cnt = 0; row_wr = 0;
    end
    if (valid_o) begin
      int exp_c;
      if (first_v) exp_c = start_cyc + SETTLE + 1;
      else if (b_col == 0) exp_c = last_v + SETTLE + 6;
      else exp_c = last_v + SETTLE + 3;
      chk(cyc == exp_c, "R6 strobe cycle", cyc, exp_c);
      chk(col_d_o == (b_col == 0), "R2/R3 col_d at sample", col_d_o, b_col == 0);
      chk(row_d_o == (b_row == 0), "R2 row_d at sample", row_d_o, b_row == 0);
      if (b_col < COLS) row_bits[b_col] = comp_i;
      b_col++; last_v = cyc; first_v = 0;
    end
    if (col_clk_o) begin
      chk(!prev_cs, "R5 col clk width", 1, 0);
      chk(col_d_o == (b_cs == 0), "R3 col_d on col clk", col_d_o, b_cs == 0);
      chk(b_cs == b_col - 1, "R4 col clk follows sample", b_cs, b_col - 1);
      held_cd = col_d_o;
      b_cs++;
    end
    if (prev_cs && !col_clk_o)
      chk(col_d_o == held_cd, "R5 col_d hold", col_d_o, held_cd);
    if (mem_we_o) begin
      chk(b_col == COLS && b_cs == COLS, "R4 flush before write", b_cs, COLS);
      chk(mem_addr_o == AW'(b_pass * ROWS + b_row), "R9 address", mem_addr_o, b_pass * ROWS + b_row);
      chk(mem_wdata_o == row_bits, "R7 row word", mem_wdata_o, row_bits);
      chk(!row_wr, "R7 one write per row", 1, 0);
      row_wr = 1; wr_cnt++; last_addr = int'(mem_addr_o);
    end
    if (row_clk_o) begin
      chk(!prev_rs, "R5 row clk width", 1, 0);
      chk(row_wr, "R8 row clk after write", row_wr, 1);
      chk(col_d_o == (b_row != ROWS - 1), "R8 col_d on row clk", col_d_o, b_row != ROWS - 1);
      chk(row_d_o == (b_row == 0), "R8 row_d on row clk", row_d_o, b_row == 0);
      held_cd = col_d_o; held_rd = row_d_o;
      b_col = 0; b_cs = 0; row_wr = 0;
      if (b_row == ROWS - 1) begin
        b_row = 0; b_pass++;
        if (b_pass == SAMPLES) begin
          active = 0;
          frames_done++;
        end
      end else b_row++;
    end
    if (prev_rs && !row_clk_o)
      chk(col_d_o == held_cd && row_d_o == held_rd, "R5 row data hold", {col_d_o, row_d_o}, {held_cd, held_rd});
    chk(!(col_clk_o && row_clk_o), "R11 clocks exclusive", {col_clk_o, row_clk_o}, 0);
    prev_cs = col_clk_o; prev_rs = row_clk_o;
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk({col_d_o, col_clk_o, row_d_o, row_clk_o, valid_o, mem_we_o} == 6'b0,
          "R1 reset state", {col_d_o, col_clk_o, row_d_o, row_clk_o, valid_o, mem_we_o}, 0);
    end
    for (int f = 0; f < 4; f++) begin
      mode = f;
      repeat (2 + ($urandom % 5)) @(posedge clk);
      pulse_start();
      if (f == 3) begin
        for (int k = 0; k < 3; k++) begin
          repeat (5 + ($urandom % 40)) @(posedge clk);
          if (active) begin
            #1 start_i = 1'b1;
            @(posedge clk); #1 start_i = 1'b0;
          end
        end
      end
      wait (frames_done == f + 1);
      chk(wr_cnt == SAMPLES * ROWS, "R9/R10 writes per frame", wr_cnt, SAMPLES * ROWS);
      chk(last_addr == SAMPLES * ROWS - 1, "R9 last address", last_addr, SAMPLES * ROWS - 1);
      repeat (12) @(negedge clk);
      chk(!valid_o && !col_d_o && !row_d_o, "R10 idle after frame", {valid_o, col_d_o, row_d_o}, 0);
    end
    summary();
  end

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    chk(0, "watchdog expired", wd, 0);
    summary();
  end
endmodule